// File: doc/BRIEF.md
# Sum of Absolute Differences Unit

This block measures how much two 16x16 pixel blocks differ. Each block is held as a 256-entry array of 8-bit samples in an external memory with synchronous reads. After a `go` pulse the unit walks an index through every entry. It drives one shared address to both memories and takes the absolute difference of each returned byte pair. It adds that difference into a 32-bit running total.

When the whole array has been summed, the total is copied into an output register that drives `sad`, and `done` pulses for one cycle. A caller compares `sad` against its own threshold to decide whether a frame can be sent as a difference. Between runs, and for the whole of a run, `sad` keeps the last published result.

Top module: `sad_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sad` is 0, `done` is 0 and `memAddr` is 0.
- R2: A `go` sampled high while the unit is idle starts a run. A `go` sampled while a run is in progress is ignored: that run finishes with the same timing and result, and it produces exactly one `done`.
- R3: The published `sad` equals the sum over all 256 entries of |A[k] - B[k]|. Both bytes are unsigned, so the largest result is 256*255 = 65280.
- R4: During a run `memAddr` starts at 0 and only ever steps up by one. It presents every address from 0 to 255 in ascending order, and the memory returns data one cycle after the address.
- R5: `done` is high for exactly one cycle. It first rises 516 clock edges after the edge that samples `go`, counting that edge as the first. In that same cycle `sad` first shows the new result.
- R6: `sad` does not change during a run. It changes only in the cycle in which `done` is high.
- R7: The running total is cleared at the start of every run, so repeating a run on the same data gives the same result.
- R8: While the unit is idle and `go` is low, `done` stays low and `sad` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start request, sampled while idle |
| memAddr | output | 8 | Address shared by both pixel memories |
| pixA | input | 8 | Read data from array A, one cycle after the address |
| pixB | input | 8 | Read data from array B, one cycle after the address |
| sad | output | 32 | Last published sum of absolute differences |
| done | output | 1 | One-cycle pulse when `sad` updates |

## Verification
The assertions assume that `pixA` and `pixB` come from memories with exactly one cycle of read latency addressed by `memAddr`. They also assume that the arrays do not change while a run is in progress. The bench meets this with registered array models and by loading each pattern only before `go`. It holds `go` to single-cycle pulses, except for one deliberate pulse in the middle of a run that tests R2.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef struct packed {
    logic clearSum;   // zero total and index
    logic accum;      // add current pair, advance index
    logic publish;    // copy total to output register
  } sadCtrl_t;
endpackage

// File: rtl/sad_datapath.sv
module sad_datapath
  import sad_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int DEPTH = 256,
  parameter int SUM_W = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int IDX_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  sadCtrl_t          ctrl,
  input  logic [PIX_W-1:0]  pixA,
  input  logic [PIX_W-1:0]  pixB,
  output logic [ADDR_W-1:0] memAddr,
  output logic              idxEnd,
  output logic [SUM_W-1:0]  sad,
  output logic              done
);
  logic [IDX_W-1:0] idx;
  logic [SUM_W-1:0] sumReg;
  logic [PIX_W-1:0] absDiff;

  always_comb begin
    if (pixA > pixB) absDiff = pixA - pixB;
    else             absDiff = pixB - pixA;
  end

  assign memAddr = idx[ADDR_W-1:0];
  assign idxEnd  = (idx >= IDX_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      sumReg <= '0;
      sad    <= '0;
      done   <= 1'b0;
    end else begin
      done <= ctrl.publish;
      if (ctrl.clearSum) begin
        idx    <= '0;
        sumReg <= '0;
      end else if (ctrl.accum) begin
        idx    <= idx + 1'b1;
        sumReg <= sumReg + SUM_W'(absDiff);
      end
      if (ctrl.publish) sad <= sumReg;
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R6
  sad_hold_chk: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(sad));
  // R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst) idx <= IDX_W'(DEPTH));
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.accum |=> sumReg >= $past(sumReg));
endmodule

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     go,
  input  logic     idxEnd,
  output sadCtrl_t ctrl
);
  typedef enum logic [2:0] {S_IDLE, S_INIT, S_CHECK, S_ACCUM, S_FINISH} state_t;
  state_t state, nextState;

  always_comb begin
    nextState = state;
    ctrl = '0;
    unique case (state)
      S_IDLE:   if (go) nextState = S_INIT;
      S_INIT:   begin ctrl.clearSum = 1'b1; nextState = S_CHECK; end
      S_CHECK:  nextState = idxEnd ? S_FINISH : S_ACCUM;
      S_ACCUM:  begin ctrl.accum = 1'b1; nextState = S_CHECK; end
      S_FINISH: begin ctrl.publish = 1'b1; nextState = S_IDLE; end
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.clearSum, ctrl.accum, ctrl.publish}));
  // R2
  busy_go_chk: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |=> (state != S_INIT));
endmodule

// File: rtl/sad_unit.sv
module sad_unit
  import sad_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  output logic [7:0]  memAddr,
  input  logic [7:0]  pixA,
  input  logic [7:0]  pixB,
  output logic [31:0] sad,
  output logic        done
);
  sadCtrl_t ctrl;
  logic idxEnd;

  sad_ctrl u_ctrl (
    .clk(clk), .rst(rst), .go(go), .idxEnd(idxEnd), .ctrl(ctrl)
  );

  sad_datapath #(.PIX_W(8), .DEPTH(256), .SUM_W(32)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .pixA(pixA), .pixB(pixB),
    .memAddr(memAddr), .idxEnd(idxEnd), .sad(sad), .done(done)
  );
endmodule

// File: tb/sad_unit_tb.sv
module sad_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY = 516;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic [7:0] memAddr, pixA, pixB;
  logic [31:0] sad;
  logic done;

  logic [7:0] memA [256];
  logic [7:0] memB [256];

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    pixA <= memA[memAddr];
    pixB <= memB[memAddr];
  end

  sad_unit u_dut (
    .clk(clk), .rst(rst), .go(go), .memAddr(memAddr),
    .pixA(pixA), .pixB(pixB), .sad(sad), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic loadPattern(input int kind, input int seed);
    logic [15:0] lfsr;
    lfsr = 16'(seed) | 16'h1;
    for (int k = 0; k < 256; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (kind)
        0: begin memA[k] = 8'd0;   memB[k] = 8'd0;   end
        1: begin memA[k] = 8'd255; memB[k] = 8'd0;   end
        2: begin memA[k] = 8'd0;   memB[k] = 8'd255; end
        3: begin memA[k] = 8'(k);  memB[k] = 8'(255 - k); end
        4: begin memA[k] = lfsr[7:0]; memB[k] = lfsr[15:8]; end
        default: begin memA[k] = 8'(k * 3); memB[k] = 8'(k * 3); end
      endcase
    end
  endtask

  function automatic logic [31:0] expectedSad();
    logic [31:0] s = 0;
    for (int k = 0; k < 256; k++)
      s += (memA[k] > memB[k]) ? 32'(memA[k] - memB[k]) : 32'(memB[k] - memA[k]);
    return s;
  endfunction

  task automatic runOnce(input string tag, input bit midGo);
    logic [31:0] exp, prevSad;
    int cycles, sadMoves, addrBad, doneCount;
    logic [7:0] lastAddr, maxAddr;
    exp = expectedSad();
    prevSad = sad;
    sadMoves = 0; addrBad = 0; doneCount = 0;
    lastAddr = 8'd0; maxAddr = 8'd0;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    cycles = 1;
    while (!done && cycles < 2000) begin
      if (sad !== prevSad) sadMoves++;
      if (memAddr != lastAddr) begin
        if (memAddr != lastAddr + 8'd1 && !(memAddr == 8'd0 && lastAddr == 8'd255)) addrBad++;
        lastAddr = memAddr;
        if (memAddr > maxAddr) maxAddr = memAddr;
      end
      go = (midGo && cycles == 100);
      @(negedge clk);
      cycles++;
    end
    go = 1'b0;
    doneCount = done ? 1 : 0;
    $display("run %s sad=%0d", tag, sad);
    check("R3 sad value", sad, exp);
    check("R5 latency", 32'(cycles), 32'(LATENCY));
    check("R6 sad held during run", 32'(sadMoves), 32'd0);
    check("R4 ascending addresses", 32'(addrBad), 32'd0);
    check("R4 top address reached", 32'(maxAddr), 32'd255);
    @(negedge clk);
    check("R5 done one cycle", 32'(done), 32'd0);
    for (int k = 0; k < 600; k++) begin
      if (done) doneCount++;
      @(negedge clk);
    end
    if (midGo) check("R2 mid-run go ignored, single done", 32'(doneCount), 32'd1);
    else       check("R8 no done while idle", 32'(doneCount), 32'd1);
    check("R8 sad kept while idle", sad, exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    loadPattern(0, 1);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sad reset", sad, 32'd0);
    check("R1 done reset", 32'(done), 32'd0);
    check("R1 addr reset", 32'(memAddr), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sad after reset", sad, 32'd0);
    check("R1 done after reset", 32'(done), 32'd0);

    loadPattern(1, 1); runOnce("a_max", 1'b0);
    loadPattern(2, 1); runOnce("b_max", 1'b0);
    loadPattern(3, 1); runOnce("ramp", 1'b1);
    for (int s = 1; s <= 4; s++) begin
      loadPattern(4, s * 977);
      runOnce("lfsr", (s == 2));
    end
    // R7 repeat on same data
    runOnce("repeat", 1'b0);
    loadPattern(5, 1); runOnce("equal", 1'b0);
    loadPattern(0, 1); runOnce("zero", 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule